// File: doc/BRIEF.md
# Frame Writeback Control Register Block

This block is the register-mapped control front end of an engine that writes rendered frames out to memory. Software programs a destination address, a line pitch, the frame dimensions and a control word, then sets a start bit. The block holds these settings and reports progress. It runs a small sequencer that moves the engine from idle to running, and from running to a draining abort state. It tells the datapath when to begin a frame and when to stop writing. It raises a level interrupt once the engine has come back to idle.

The datapath is shown only by three wires. It returns a line-committed pulse and a frame-finished pulse, and it receives a frame-start pulse and a stop-writes level. A powerdown bit in the control word drives a memory sleep output.

The sequencer has three states. IDLE moves to RUN when software writes the control word with the start bit set (transition *launch*). RUN moves back to IDLE on frame-finished (*complete*). With the rearm bit set, RUN stays in RUN on frame-finished and issues a new frame-start (*restart*). RUN moves to ABORT on a control write with the abort bit set (*kill*). ABORT holds stop-writes for a fixed number of cycles and then returns to IDLE (*drained*).

Top module: `frame_wb_ctrl`

## Requirements
- R1: After reset, the pointer, pitch, dimension and progress registers read 0. The control word at offset 0x0C reads 0x5440_0000. The outputs irq, stop_writes, frame_start and mem_sleep are 0.
- R2: Control bits 31:24 always read 0x54 and bits 23:22 always read 0b01, whatever is written to them.
- R3: A control write with bit 0 set while idle makes bit 1 (busy) read 1 from the next cycle. It gives frame_start for exactly one cycle and clears progress. Bit 0 always reads 0.
- R4: frame_done while running, with bit 15 clear, makes busy read 0 from the next cycle.
- R5: A control write with bit 0 set while busy is ignored. No frame_start pulse occurs, busy stays 1 and progress keeps its value.
- R6: A control write with bit 14 set while running raises stop_writes from the next cycle. stop_writes holds for exactly DRAIN_CYCLES cycles (default 4), after which busy reads 0. Bit 14 always reads 0.
- R7: irq is high exactly when bit 2 is set, the engine is idle, and a frame has ended (completed or aborted) since the last start. Clearing bit 2 drops irq on the next cycle.
- R8: With bit 15 set, frame_done while running gives a one-cycle frame_start and busy stays 1.
- R9: Control bits 21:15 and 13:2 read back as written. Bit 21 drives mem_sleep.
- R10: The pointer (0x00) and dimension (0x08) registers keep all 32 bits. The pitch register (0x04) reads with bits 3:0 forced to 0.
- R11: Progress (0x10) counts line_done pulses while running and ignores writes.
- R12: frame_done in the same cycle as an abort write ends the frame normally. stop_writes stays 0 and busy reads 0 next cycle.
- R13: An abort write while idle has no effect. stop_writes and busy stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| line_done | input | 1 | One line committed to memory |
| frame_done | input | 1 | Datapath finished the frame |
| frame_start | output | 1 | One-cycle pulse starting a frame |
| stop_writes | output | 1 | Datapath must stop memory writes |
| mem_sleep | output | 1 | Internal memory powerdown |
| irq | output | 1 | Idle interrupt, level high |

## Verification
Two events can land in the same cycle: the datapath's frame-finished pulse and a software abort write, which compete for the RUN state's exit. The bench drives frame_done and the abort write across one shared clock edge. It then expects a normal completion: stop_writes never rises, busy reads 0 and the idle interrupt is asserted. A start write during a running frame is provoked the same way. There the bench checks that no second frame-start pulse occurs and that the progress count survives.

// File: rtl/frame_wb_pkg.sv
package frame_wb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_ABORT = 2'd2
    } wb_state_e;

    // register byte offsets
    localparam int OFS_PTR   = 'h00;
    localparam int OFS_PITCH = 'h04;
    localparam int OFS_DIM   = 'h08;
    localparam int OFS_CTRL  = 'h0C;
    localparam int OFS_PROG  = 'h10;

    // control word bit positions
    localparam int B_GO    = 0;
    localparam int B_BUSY  = 1;
    localparam int B_IE    = 2;
    localparam int B_ABORT = 14;
    localparam int B_REARM = 15;
    localparam int B_PDN   = 21;

    // bits held in storage: 21:15 and 13:2
    localparam logic [31:0] CTRL_KEEP = 32'h003F_BFFC;
    // fixed identification field, bits 31:22
    localparam logic [9:0]  CTRL_ID   = {8'h54, 2'b01};

endpackage

// File: rtl/frame_wb_regs.sv
module frame_wb_regs
    import frame_wb_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int PROG_W      = 16,
    parameter int PITCH_ALIGN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [31:0]       wdata,
    input  logic              busy,
    input  logic [PROG_W-1:0] progress,
    output logic [31:0]       rdata,
    output logic              go_req,
    output logic              abort_req,
    output logic              irq_en,
    output logic              rearm,
    output logic              mem_sleep
);
    localparam logic [31:0] PITCH_MASK = ~((32'd1 << PITCH_ALIGN) - 32'd1);

    logic [31:0] ptr_q, pitch_q, dim_q, ctrl_q;
    logic        hit_ptr, hit_pitch, hit_dim, hit_ctrl, hit_prog;

    assign hit_ptr   = (addr == ADDR_W'(OFS_PTR));
    assign hit_pitch = (addr == ADDR_W'(OFS_PITCH));
    assign hit_dim   = (addr == ADDR_W'(OFS_DIM));
    assign hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
    assign hit_prog  = (addr == ADDR_W'(OFS_PROG));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            pitch_q <= '0;
            dim_q   <= '0;
            ctrl_q  <= '0;
        end else if (wr) begin
            if (hit_ptr)   ptr_q   <= wdata;
            if (hit_pitch) pitch_q <= wdata & PITCH_MASK;
            if (hit_dim)   dim_q   <= wdata;
            if (hit_ctrl)  ctrl_q  <= wdata & CTRL_KEEP;
        end
    end

    assign go_req    = wr && hit_ctrl && wdata[B_GO];
    assign abort_req = wr && hit_ctrl && wdata[B_ABORT];
    assign irq_en    = ctrl_q[B_IE];
    assign rearm     = ctrl_q[B_REARM];
    assign mem_sleep = ctrl_q[B_PDN];

    always_comb begin
        rdata = '0;
        if (hit_ptr)   rdata = ptr_q;
        if (hit_pitch) rdata = pitch_q;
        if (hit_dim)   rdata = dim_q;
        if (hit_ctrl)  rdata = {CTRL_ID, ctrl_q[21:15], 1'b0, ctrl_q[13:2], busy, 1'b0};
        if (hit_prog)  rdata = 32'(progress);
    end

    // R9: powerdown level follows the last control write
    a_r9_pdn_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_ctrl) |=> (mem_sleep == $past(wdata[B_PDN])));

endmodule

// File: rtl/frame_wb_seq.sv
module frame_wb_seq
    import frame_wb_pkg::*;
#(
    parameter int DRAIN_CYCLES = 4,
    parameter int PROG_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_req,
    input  logic              abort_req,
    input  logic              rearm,
    input  logic              irq_en,
    input  logic              line_done,
    input  logic              frame_done,
    output logic              busy,
    output logic              stop_writes,
    output logic              frame_start,
    output logic              irq,
    output logic [PROG_W-1:0] progress
);
    localparam int          CNT_W = $clog2(DRAIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRAIN_CYCLES - 1);

    wb_state_e        st, st_nx;
    logic [CNT_W-1:0] drain_cnt;
    logic             ended_q;
    logic             launch;

    assign launch = (st == ST_IDLE) && go_req;

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (go_req) st_nx = ST_RUN;
            ST_RUN: begin
                if (frame_done)     st_nx = rearm ? ST_RUN : ST_IDLE;
                else if (abort_req) st_nx = ST_ABORT;
            end
            ST_ABORT: if (drain_cnt == CNT_LAST) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // registered outputs and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_start <= 1'b0;
            drain_cnt   <= '0;
            progress    <= '0;
            ended_q     <= 1'b0;
        end else begin
            frame_start <= launch || ((st == ST_RUN) && frame_done && rearm);
            drain_cnt   <= (st == ST_ABORT) ? drain_cnt + 1'b1 : '0;
            if (launch)
                progress <= '0;
            else if ((st == ST_RUN) && line_done)
                progress <= progress + 1'b1;
            if (launch)
                ended_q <= 1'b0;
            else if ((st != ST_IDLE) && (st_nx == ST_IDLE))
                ended_q <= 1'b1;
        end
    end

    assign busy        = (st != ST_IDLE);
    assign stop_writes = (st == ST_ABORT);
    assign irq         = irq_en && ended_q && (st == ST_IDLE);

    a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && go_req) |=> (busy && frame_start));
    a_r4_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && frame_done && !rearm) |=> !busy);
    a_r5_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && go_req && !frame_done && !abort_req) |=> (busy && !frame_start));
    a_r6_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && abort_req && !frame_done) |=> stop_writes);
    a_r6_drain_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stop_writes |-> (drain_cnt <= CNT_LAST));
    a_r12_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && frame_done && abort_req) |=> !stop_writes);

endmodule

// File: rtl/frame_wb_ctrl.sv
module frame_wb_ctrl
    import frame_wb_pkg::*;
#(
    parameter int ADDR_W       = 5,
    parameter int PROG_W       = 16,
    parameter int PITCH_ALIGN  = 4,
    parameter int DRAIN_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              line_done,
    input  logic              frame_done,
    output logic              frame_start,
    output logic              stop_writes,
    output logic              mem_sleep,
    output logic              irq
);
    logic              go_req, abort_req, irq_en, rearm, busy;
    logic [PROG_W-1:0] progress;

    frame_wb_regs #(
        .ADDR_W(ADDR_W), .PROG_W(PROG_W), .PITCH_ALIGN(PITCH_ALIGN)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
        .busy(busy), .progress(progress), .rdata(reg_rdata),
        .go_req(go_req), .abort_req(abort_req), .irq_en(irq_en),
        .rearm(rearm), .mem_sleep(mem_sleep)
    );

    frame_wb_seq #(
        .DRAIN_CYCLES(DRAIN_CYCLES), .PROG_W(PROG_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .go_req(go_req), .abort_req(abort_req),
        .rearm(rearm), .irq_en(irq_en), .line_done(line_done),
        .frame_done(frame_done), .busy(busy), .stop_writes(stop_writes),
        .frame_start(frame_start), .irq(irq), .progress(progress)
    );

    a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && !busy));
    a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_en) |-> !irq);

endmodule

// File: tb/frame_wb_ctrl_test.sv
module frame_wb_ctrl_test;
    localparam int DRAIN = 4;
    localparam logic [4:0] A_PTR = 5'h00, A_PITCH = 5'h04, A_DIM = 5'h08,
                           A_CTRL = 5'h0C, A_PROG = 5'h10;
    localparam logic [31:0] CFG  = 32'h000F_0004; // byte enables + irq enable
    localparam logic [31:0] GO   = 32'h1;
    localparam logic [31:0] KILL = 32'h4000;
    localparam logic [31:0] RARM = 32'h8000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        line_done = 1'b0, frame_done = 1'b0;
    logic        frame_start, stop_writes, mem_sleep, irq;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    frame_wb_ctrl #(.DRAIN_CYCLES(DRAIN)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_done(line_done),
        .frame_done(frame_done), .frame_start(frame_start),
        .stop_writes(stop_writes), .mem_sleep(mem_sleep), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic busy_bit(output logic b);
        logic [31:0] v;
        rd(A_CTRL, v); b = v[1];
    endtask

    task automatic pulse_done();
        frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_PTR, v);   chk("R1 ptr", v, 0);
        rd(A_PITCH, v); chk("R1 pitch", v, 0);
        rd(A_DIM, v);   chk("R1 dim", v, 0);
        rd(A_PROG, v);  chk("R1 progress", v, 0);
        rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h5440_0000);
        chk("R1 outs", {irq, stop_writes, frame_start, mem_sleep}, 0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(A_CTRL, 32'hFFFF_BFFE);
        rd(A_CTRL, v); chk("R9 R2 ctrl all", v, 32'h547F_BFFC);
        chk("R9 mem_sleep on", mem_sleep, 1);
        wr(A_CTRL, 32'h0000_0000);
        rd(A_CTRL, v); chk("R2 ctrl zero", v, 32'h5440_0000);
        chk("R9 mem_sleep off", mem_sleep, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(A_PTR, 32'hDEAD_BEEF);   rd(A_PTR, v);   chk("R10 ptr", v, 32'hDEAD_BEEF);
        wr(A_PITCH, 32'h1234_567F); rd(A_PITCH, v); chk("R10 pitch", v, 32'h1234_5670);
        wr(A_DIM, 32'h0438_0780);   rd(A_DIM, v);   chk("R10 dim", v, 32'h0438_0780);
    endtask

    task automatic t_start_finish();
        logic [31:0] v;
        wr(A_CTRL, CFG | GO);
        chk("R3 frame_start", frame_start, 1);
        rd(A_CTRL, v); chk("R3 busy/go bits", v[1:0], 2'b10);
        @(negedge clk);
        chk("R3 pulse one cycle", frame_start, 0);
        line_done = 1'b1; repeat (3) @(negedge clk); line_done = 1'b0;
        rd(A_PROG, v); chk("R11 progress 3", v, 3);
        wr(A_PROG, 32'h55); rd(A_PROG, v); chk("R11 write ignored", v, 3);
        pulse_done();
        rd(A_CTRL, v); chk("R4 busy clear", v[1], 0);
        chk("R7 irq up", irq, 1);
        wr(A_CTRL, CFG & ~32'h4);
        chk("R7 irq cleared", irq, 0);
    endtask

    task automatic t_go_busy();
        logic [31:0] v;
        wr(A_CTRL, CFG | GO);
        chk("R3 irq low running", irq, 0);
        line_done = 1'b1; repeat (2) @(negedge clk); line_done = 1'b0;
        wr(A_CTRL, CFG | GO);
        chk("R5 no pulse", frame_start, 0);
        rd(A_CTRL, v); chk("R5 busy kept", v[1], 1);
        rd(A_PROG, v); chk("R5 progress kept", v, 2);
        pulse_done();
        wr(A_CTRL, CFG | GO);
        rd(A_PROG, v); chk("R3 progress cleared", v, 0);
        pulse_done();
    endtask

    task automatic t_abort();
        logic [31:0] v;
        wr(A_CTRL, CFG | GO);
        wr(A_CTRL, CFG | KILL);
        chk("R6 stop up", stop_writes, 1);
        rd(A_CTRL, v); chk("R6 abort bit reads 0", v[14], 0);
        chk("R6 busy in abort", v[1], 1);
        repeat (DRAIN - 1) @(negedge clk);
        chk("R6 stop held", stop_writes, 1);
        @(negedge clk);
        chk("R6 stop dropped", stop_writes, 0);
        rd(A_CTRL, v); chk("R6 busy clear", v[1], 0);
        chk("R7 irq after abort", irq, 1);
    endtask

    task automatic t_abort_idle();
        logic b;
        wr(A_CTRL, CFG | KILL);
        chk("R13 stop stays 0", stop_writes, 0);
        busy_bit(b); chk("R13 busy stays 0", b, 0);
    endtask

    task automatic t_rearm();
        logic b;
        wr(A_CTRL, CFG | RARM | GO);
        @(negedge clk);
        pulse_done();
        chk("R8 restart pulse", frame_start, 1);
        busy_bit(b); chk("R8 busy stays", b, 1);
        wr(A_CTRL, CFG);
        pulse_done();
        busy_bit(b); chk("R4 idle after rearm off", b, 0);
    endtask

    task automatic t_collide();
        logic b;
        wr(A_CTRL, CFG | GO);
        @(negedge clk);
        frame_done = 1'b1;
        wr(A_CTRL, CFG | KILL);
        frame_done = 1'b0;
        chk("R12 no stop", stop_writes, 0);
        busy_bit(b); chk("R12 idle", b, 0);
        chk("R12 irq", irq, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_regs();
        t_start_finish();
        t_go_busy();
        t_abort();
        t_abort_idle();
        t_rearm();
        t_collide();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule